// File: doc/BRIEF.md
# Fractional Division Ratio Sequencer

This block runs next to a programmable integer divider in a frequency synthesizer. Once per phase-detector cycle, marked by a one-cycle strobe, it chooses the integer ratio the divider uses for the next cycle. That ratio is either the base value N or N+1. Over every F cycles it picks N+1 exactly K times, so the average ratio is N + K/F.

The choice comes from a first-order phase accumulator with modulus F. On each strobe the numerator K is added to the accumulator. When the sum reaches F, F is subtracted and that cycle's ratio is N+1. A configuration load captures new N, K and F values and clears the accumulator, so every configuration starts the same sequence. With K = 0 the block stays in integer mode and always outputs N. If K is not below F, or F is zero or larger than the largest supported modulus, an error flag is raised and the block falls back to the constant ratio N.

The ratio and the overflow indication are plain registered control outputs. They change only on a strobe. The block has no data stream, so it has no valid/ready interface and there is no back-pressure to respect.

Top module: `fns_sequencer`

## Requirements
- R1: After reset, `ratio_out` is 0, `ovf_out` is 0 and `cfg_err` is 0.
- R2: A strobe that is not paired with a load updates the outputs on the next edge. `ratio_out` becomes N+1 with `ovf_out`=1 when accumulator+K is at least F, and becomes N with `ovf_out`=0 otherwise.
- R3: With a valid configuration, any F consecutive strobes after a load contain exactly K strobes with `ovf_out`=1.
- R4: With N=2000, K=1 and F=16, the first fifteen strobes after a load give 2000 and the sixteenth gives 2001.
- R5: With K=0 and a valid F, every strobe gives ratio N with `ovf_out`=0.
- R6: A load with K ≥ F, F=0 or F > 2^FRAC_W sets `cfg_err`=1. While the flag is set, strobes give ratio N with `ovf_out`=0. A load of a valid configuration clears the flag.
- R7: A load clears the accumulator, so the ratio sequence after a reload matches the sequence after the first load of the same values.
- R8: In a cycle without a strobe, `ratio_out` and `ovf_out` hold their values.
- R9: The largest modulus, F = 2^FRAC_W (2^24 by default), is supported. With K = 2^(FRAC_W-1), the ratios alternate N, N+1, N, N+1, and so on.
- R10: When a load and a strobe fall in the same cycle, the load takes effect and the strobe is ignored: the outputs hold their values.
- R11: The accumulator always stays below F while the configuration is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle strobe, once per reference cycle |
| cfg_load | input | 1 | Captures the cfg_* values and clears the accumulator |
| cfg_int | input | INT_W | Base integer ratio N |
| cfg_num | input | FRAC_W | Fraction numerator K |
| cfg_mod | input | FRAC_W+1 | Fraction modulus F |
| ratio_out | output | INT_W+1 | Ratio for the coming cycle: N or N+1 |
| ovf_out | output | 1 | High when the last strobe chose N+1 |
| cfg_err | output | 1 | The loaded configuration is invalid |

## Verification
The bench targets these corner cases and the failure each one would expose:

- **Modulus at 2^24.** If the wrap test were one bit too narrow, overflows would be lost or extra ones would appear.
- **K = F−1 and K = 0.** An off-by-one in the comparison would give F or F−2 overflows per window, or would wrongly add N+1 in integer mode.
- **Reloading the same configuration.** If the accumulator were not cleared, the phase of the pattern would shift.
- **A strobe in the same cycle as a load.** If the strobe were not ignored, the block would step once using stale values.
- **Invalid configurations.** Without the error fallback, the accumulator would keep wrapping.

Randomly chosen small configurations are each run for a full window of F strobes, and the number of overflows is compared with K.

// File: rtl/fns_pkg.sv
package fns_pkg;
  localparam int DEF_INT_W  = 16;
  localparam int DEF_FRAC_W = 24;

  typedef enum logic {
    STEP_BASE  = 1'b0,
    STEP_PLUS1 = 1'b1
  } step_kind_e;
endpackage

// File: rtl/fns_cfg.sv
module fns_cfg #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 24,
  localparam int MOD_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  n_in,
  input  logic [FRAC_W-1:0] k_in,
  input  logic [MOD_W-1:0]  f_in,
  output logic [INT_W-1:0]  n_q,
  output logic [FRAC_W-1:0] k_q,
  output logic [MOD_W-1:0]  f_q,
  output logic              err_q
);
  localparam logic [MOD_W-1:0] MAX_MOD = {1'b1, {FRAC_W{1'b0}}};

  logic bad_cfg;
  always_comb begin
    bad_cfg = 1'b0;
    if (f_in == '0) bad_cfg = 1'b1;
    if (f_in > MAX_MOD) bad_cfg = 1'b1;
    if ({1'b0, k_in} >= f_in) bad_cfg = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      k_q   <= '0;
      f_q   <= MOD_W'(1);
      err_q <= 1'b0;
    end else if (load) begin
      n_q   <= n_in;
      k_q   <= k_in;
      f_q   <= f_in;
      err_q <= bad_cfg;
    end
  end

  // R6: an invalid modulus is always flagged after its load
  p_zero_mod_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load && (f_in == '0) |=> err_q);
endmodule

// File: rtl/fns_phase_acc.sv
module fns_phase_acc #(
  parameter int FRAC_W = 24,
  localparam int MOD_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [FRAC_W-1:0] k,
  input  logic [MOD_W-1:0]  f,
  output logic              wrap
);
  logic [FRAC_W-1:0] acc_q;
  logic [MOD_W-1:0]  sum;
  logic [MOD_W-1:0]  nxt;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, k};
    wrap = (sum >= f);
    nxt  = wrap ? (sum - f) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (step) acc_q <= nxt[FRAC_W-1:0];
  end

  // R11: the phase stays inside the modulus
  p_acc_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (f != '0) |-> ({1'b0, acc_q} < f));

  // R5: a zero numerator never produces a wrap while the phase is in range
  p_int_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (k == '0) && (f != '0) |-> !wrap);
endmodule

// File: rtl/fns_ratio_reg.sv
module fns_ratio_reg #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             plus1,
  input  logic [INT_W-1:0] n,
  output logic [INT_W:0]   ratio,
  output logic             ovf
);
  import fns_pkg::*;

  step_kind_e kind;
  assign kind = plus1 ? STEP_PLUS1 : STEP_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio <= '0;
      ovf   <= 1'b0;
    end else if (tick) begin
      ratio <= {1'b0, n} + ((kind == STEP_PLUS1) ? (INT_W+1)'(1) : '0);
      ovf   <= (kind == STEP_PLUS1);
    end
  end

  // R8: the outputs hold when there is no strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ratio) && $stable(ovf));
endmodule

// File: rtl/fns_sequencer.sv
module fns_sequencer #(
  parameter int INT_W  = fns_pkg::DEF_INT_W,
  parameter int FRAC_W = fns_pkg::DEF_FRAC_W,
  localparam int MOD_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              cfg_load,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [MOD_W-1:0]  cfg_mod,
  output logic [INT_W:0]    ratio_out,
  output logic              ovf_out,
  output logic              cfg_err
);
  logic [INT_W-1:0]  n_q;
  logic [FRAC_W-1:0] k_q;
  logic [MOD_W-1:0]  f_q;
  logic              wrap;
  logic              tick_eff;
  logic              acc_step;

  assign tick_eff = ref_tick & ~cfg_load;
  assign acc_step = tick_eff & ~cfg_err;

  fns_cfg #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .n_in(cfg_int), .k_in(cfg_num), .f_in(cfg_mod),
    .n_q(n_q), .k_q(k_q), .f_q(f_q), .err_q(cfg_err)
  );

  fns_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .step(acc_step),
    .k(k_q), .f(f_q), .wrap(wrap)
  );

  fns_ratio_reg #(.INT_W(INT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick_eff),
    .plus1(wrap & ~cfg_err), .n(n_q),
    .ratio(ratio_out), .ovf(ovf_out)
  );

  // R2: the ratio after a strobe is the base plus the overflow bit
  p_ratio_matches_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick && !cfg_load |=> ratio_out == ({1'b0, n_q} + (INT_W+1)'(ovf_out)));

  // R6: an erroneous configuration never overflows
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && ref_tick && !cfg_load |=> !ovf_out);

  // R10: a load in the same cycle as a strobe leaves the outputs unchanged
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> $stable(ratio_out) && $stable(ovf_out));
endmodule

// File: tb/fns_sequencer_test.sv
module fns_sequencer_test;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 24;
  localparam int MOD_W  = FRAC_W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_tick = 1'b0;
  logic              cfg_load = 1'b0;
  logic [INT_W-1:0]  cfg_int = '0;
  logic [FRAC_W-1:0] cfg_num = '0;
  logic [MOD_W-1:0]  cfg_mod = '0;
  logic [INT_W:0]    ratio_out;
  logic              ovf_out;
  logic              cfg_err;

  int total = 0;
  int bad = 0;

  // Bench model state, computed from the requirements
  longint m_n, m_k, m_f, m_acc;
  bit     m_err;

  always #2 clk = ~clk;

  fns_sequencer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_load(cfg_load),
    .cfg_int(cfg_int), .cfg_num(cfg_num), .cfg_mod(cfg_mod),
    .ratio_out(ratio_out), .ovf_out(ovf_out), .cfg_err(cfg_err)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cfg_bad(longint k, longint f);
    return (f == 0) || (f > (64'd1 << FRAC_W)) || (k >= f);
  endfunction

  task automatic load_cfg(longint n, longint k, longint f);
    @(negedge clk);
    cfg_int = INT_W'(n); cfg_num = FRAC_W'(k); cfg_mod = MOD_W'(f);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_n = n; m_k = k; m_f = f; m_acc = 0; m_err = cfg_bad(k, f);
  endtask

  // One strobe; returns the expected overflow bit and checks both outputs
  task automatic tick_chk(string req, output bit exp_ovf);
    longint s;
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    exp_ovf = 1'b0;
    if (!m_err) begin
      s = m_acc + m_k;
      if (s >= m_f) begin exp_ovf = 1'b1; s = s - m_f; end
      m_acc = s;
    end
    check(req, ratio_out, m_n + exp_ovf);
    check(req, ovf_out, exp_ovf);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit o;
    int cnt;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ratio", ratio_out, 0);
    check("R1 ovf", ovf_out, 0);
    check("R1 err", cfg_err, 0);
    rst_n = 1'b1;

    // R4: the worked example
    load_cfg(2000, 1, 16);
    for (int i = 0; i < 15; i++) tick_chk("R4", o);
    tick_chk("R4 last", o);
    check("R4 sixteenth is plus one", ratio_out, 2001);

    // R8: hold between strobes
    repeat (5) @(negedge clk);
    check("R8 hold ratio", ratio_out, 2001);
    check("R8 hold ovf", ovf_out, 1);

    // R5: integer mode
    load_cfg(123, 0, 7);
    for (int i = 0; i < 10; i++) tick_chk("R5", o);

    // R3: K = F-1 gives F-1 overflows per window
    load_cfg(50, 9, 10);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin tick_chk("R3", o); cnt += o; end
    check("R3 count K=F-1", cnt, 9);

    // R3, R2: random configurations, full window each
    for (int t = 0; t < 25; t++) begin
      longint f = 1 + ($urandom % 200);
      longint k = $urandom % f;
      longint n = $urandom % 60000;
      load_cfg(n, k, f);
      cnt = 0;
      for (int i = 0; i < f; i++) begin tick_chk("R2", o); cnt += o; end
      check("R3 random window count", cnt, k);
    end

    // R7: a reload restarts the same sequence
    load_cfg(300, 3, 7);
    for (int i = 0; i < 4; i++) tick_chk("R7 first", o);
    load_cfg(300, 3, 7);
    for (int i = 0; i < 7; i++) tick_chk("R7 reload", o);

    // R10: load together with a strobe; the strobe is ignored
    load_cfg(40, 1, 2);
    tick_chk("R10 pre", o);
    @(negedge clk);
    cfg_int = 16'd41; cfg_num = 24'd1; cfg_mod = 25'd2;
    cfg_load = 1'b1; ref_tick = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; ref_tick = 1'b0;
    check("R10 ratio held", ratio_out, 40);
    check("R10 ovf held", ovf_out, 0);
    m_n = 41; m_k = 1; m_f = 2; m_acc = 0; m_err = 0;
    tick_chk("R10 after", o);
    tick_chk("R10 after", o);

    // R6: invalid configurations
    load_cfg(77, 5, 5);
    check("R6 err K=F", cfg_err, 1);
    for (int i = 0; i < 4; i++) tick_chk("R6", o);
    load_cfg(77, 0, 0);
    check("R6 err F=0", cfg_err, 1);
    tick_chk("R6 F=0", o);
    load_cfg(77, 1, (64'd1 << FRAC_W) + 1);
    check("R6 err F too big", cfg_err, 1);
    load_cfg(77, 1, 3);
    check("R6 err cleared", cfg_err, 0);

    // R9: largest modulus
    load_cfg(1000, 64'd1 << (FRAC_W-1), 64'd1 << FRAC_W);
    check("R9 valid", cfg_err, 0);
    for (int i = 0; i < 6; i++) begin
      tick_chk("R9", o);
      check("R9 alternation", o, i % 2);
    end
    load_cfg(1000, (64'd1 << FRAC_W) - 1, 64'd1 << FRAC_W);
    for (int i = 0; i < 6; i++) tick_chk("R9 K=F-1", o);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule